// File: doc/BRIEF.md
# Serial Divider-Ratio Programming Port

This block is the programming front end of a frequency synthesizer. Three wires carry the settings: a serial data line, a serial clock and a load strobe. Each rising edge of the serial clock moves one data bit into a chain made of an 18-bit word register followed by a one-bit destination flag. Once a full 19-bit frame has been clocked in, the controller raises the load strobe. The destination flag then decides which holding register takes the word. One is a 14-bit reference divide ratio. The other is an 18-bit main divide ratio made of a 6-bit swallow count and a 12-bit program count.

All three serial inputs are asynchronous to the system clock `clk_i`. Each is passed through a synchronizer, and serial clock edges are found on the synchronized copy. A holding register follows the word chain on every system cycle while the load strobe is high and the flag selects it, which makes it act as a transparent latch. When the strobe drops, it keeps its value. The divider counters, the prescaler and the phase comparator are outside this block.

Top module: `synth_prog_if`

## Requirements
- R1: After reset, `ref_div_o`, `swallow_o` and `main_div_o` are all zero.
- R2: A frame is 19 bits sent least significant bit first. Word bits w0..w17 come first and the destination flag comes last. When the flag is 0 and the strobe is raised, `swallow_o` = w5..w0 and `main_div_o` = w17..w6.
- R3: When the flag is 1 and the strobe is raised, `ref_div_o` = w13..w0. Word bits w14..w17 have no effect on any output.
- R4: A strobe updates only the register that the flag selects. The other register keeps its value.
- R5: Shifting a full frame while the strobe is low changes no output.
- R6: While the strobe stays high, every further serial clock edge shifts the chain, and the selected register follows the chain's new content. The new flag value is taken into account when choosing the register.
- R7: After the strobe falls, further shifting leaves every output unchanged.
- R8: Only rising serial clock edges shift. Changes on the data line while the serial clock is idle do not alter the word that is later latched.
- R9: All-ones words load as swallow 63, program count 4095 and reference 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock, asynchronous; a rising edge shifts one bit |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Load strobe, asynchronous, active high |
| ref_div_o | output | 14 | Reference divide ratio |
| swallow_o | output | 6 | Swallow count of the main divide ratio |
| main_div_o | output | 12 | Program count of the main divide ratio |

## Verification
The assertions check three things on every cycle:
- Both holding registers stay frozen while the synchronized strobe is low.
- The selected register takes the chain content one cycle after the strobe is seen, while the unselected one holds.
- The chain does not move without a detected serial clock edge.

Several behaviours can only be shown by the bench scenarios, because they depend on what is on the wires:
- The least-significant-first bit order and the flag being last.
- Word bits 14 to 17 being dropped on a reference load.
- Data-line glitches with the serial clock idle having no effect.
- The all-ones boundary values.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int unsigned SWAL_W_DEF = 6;
  localparam int unsigned MAIN_W_DEF = 12;
  localparam int unsigned REF_W_DEF  = 14;
  localparam int unsigned SYNC_DEF   = 2;

  typedef enum logic {
    DEST_MAIN = 1'b0,
    DEST_REF  = 1'b1
  } dest_sel_e;
endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sprog_shift.sv
module sprog_shift #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o,
  output logic         flag_o
);
  logic [W-1:0] word_q;
  logic         flag_q;

  // flag is the tail of the chain: the last bit of a frame lands here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      flag_q <= 1'b0;
    end else if (shift_i) begin
      word_q <= {flag_q, word_q[W-1:1]};
      flag_q <= bit_i;
    end
  end

  assign word_o = word_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/sprog_hold.sv
module sprog_hold #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int unsigned SWAL_W = SWAL_W_DEF,
  parameter int unsigned MAIN_W = MAIN_W_DEF,
  parameter int unsigned REF_W  = REF_W_DEF,
  parameter int unsigned SYNC_N = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_le_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [SWAL_W-1:0] swallow_o,
  output logic [MAIN_W-1:0] main_div_o
);
  localparam int unsigned WORD_W = SWAL_W + MAIN_W;

  logic [2:0]        sync_q;
  logic              sclk_s, sdat_s, le_s;
  logic              sclk_d;
  logic              shift_en;
  logic [WORD_W-1:0] sr_q;
  logic              ctrl_q;
  dest_sel_e         dest;
  logic              en_ref, en_main;
  logic [WORD_W-1:0] main_word;

  sprog_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_clk_i, ser_data_i, ser_le_i}),
    .q_o   (sync_q)
  );
  assign {sclk_s, sdat_s, le_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end
  assign shift_en = sclk_s & ~sclk_d;

  sprog_shift #(.W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .bit_i  (sdat_s),
    .word_o (sr_q),
    .flag_o (ctrl_q)
  );

  assign dest    = dest_sel_e'(ctrl_q);
  assign en_ref  = le_s & (dest == DEST_REF);
  assign en_main = le_s & (dest == DEST_MAIN);

  sprog_hold #(.W(REF_W)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_ref),
    .d_i   (sr_q[REF_W-1:0]),
    .q_o   (ref_div_o)
  );

  sprog_hold #(.W(WORD_W)) u_main (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_main),
    .d_i   (sr_q),
    .q_o   (main_word)
  );

  assign swallow_o  = main_word[SWAL_W-1:0];
  assign main_div_o = main_word[WORD_W-1:SWAL_W];
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
  parameter int unsigned SWAL_W = 6,
  parameter int unsigned MAIN_W = 12,
  parameter int unsigned REF_W  = 14
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     le_s,
  input logic                     ctrl_q,
  input logic                     shift_en,
  input logic [SWAL_W+MAIN_W-1:0] sr_q,
  input logic [REF_W-1:0]         ref_div_o,
  input logic [SWAL_W-1:0]        swallow_o,
  input logic [MAIN_W-1:0]        main_div_o
);
  // R2
  main_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_s && !ctrl_q) |=> ({main_div_o, swallow_o} == $past(sr_q)));

  // R3
  ref_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_s && ctrl_q) |=> (ref_div_o == $past(sr_q[REF_W-1:0])));

  // R4
  ref_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_s && !ctrl_q) |=> $stable(ref_div_o));

  // R4
  main_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_s && ctrl_q) |=> $stable({main_div_o, swallow_o}));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_s |=> ($stable(ref_div_o) && $stable({main_div_o, swallow_o})));

  // R8
  no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en |=> $stable({ctrl_q, sr_q}));
endmodule

bind synth_prog_if synth_prog_if_chk #(
  .SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .REF_W(REF_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .le_s      (le_s),
  .ctrl_q    (ctrl_q),
  .shift_en  (shift_en),
  .sr_q      (sr_q),
  .ref_div_o (ref_div_o),
  .swallow_o (swallow_o),
  .main_div_o(main_div_o)
);

// File: tb/synth_prog_if_bench.sv
module synth_prog_if_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ser_clk_i = 1'b0;
  logic        ser_data_i = 1'b0;
  logic        ser_le_i = 1'b0;
  logic [13:0] ref_div_o;
  logic [5:0]  swallow_o;
  logic [11:0] main_div_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [17:0] m_sr   = '0;
  logic        m_flag = 1'b0;
  logic [13:0] m_ref  = '0;
  logic [5:0]  m_sw   = '0;
  logic [11:0] m_mn   = '0;
  logic        m_le   = 1'b0;

  always #5 clk_i = ~clk_i;

  synth_prog_if u_synth_prog_if (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_clk_i (ser_clk_i),
    .ser_data_i(ser_data_i),
    .ser_le_i  (ser_le_i),
    .ref_div_o (ref_div_o),
    .swallow_o (swallow_o),
    .main_div_o(main_div_o)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, {4'h0, ref_div_o}, {4'h0, m_ref});
    check(req, {12'h0, swallow_o}, {12'h0, m_sw});
    check(req, {6'h0, main_div_o}, {6'h0, m_mn});
  endtask

  task automatic model_latch();
    if (m_flag) m_ref = m_sr[13:0];
    else {m_mn, m_sw} = m_sr;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk_i);
    ser_data_i = b;
    wait_n(4);
    ser_clk_i = 1'b1;
    wait_n(6);
    ser_clk_i = 1'b0;
    wait_n(4);
    m_sr   = {m_flag, m_sr[17:1]};
    m_flag = b;
    if (m_le) model_latch();
  endtask

  task automatic send_frame(input logic [17:0] w, input logic flag);
    for (int i = 0; i < 18; i++) shift_bit(w[i]);
    shift_bit(flag);
  endtask

  task automatic le_high();
    @(negedge clk_i);
    ser_le_i = 1'b1;
    m_le = 1'b1;
    model_latch();
    wait_n(8);
  endtask

  task automatic le_low();
    @(negedge clk_i);
    ser_le_i = 1'b0;
    m_le = 1'b0;
    wait_n(8);
  endtask

  task automatic t_reset();
    check("R1 ref", {4'h0, ref_div_o}, 18'h0);
    check("R1 swallow", {12'h0, swallow_o}, 18'h0);
    check("R1 main", {6'h0, main_div_o}, 18'h0);
  endtask

  task automatic t_main_load();
    send_frame(18'h2B5C7, 1'b0);
    le_high(); le_low();
    check("R2 swallow", {12'h0, swallow_o}, 18'h07);
    check("R2 main", {6'h0, main_div_o}, 18'hAD7);
    check("R4 ref untouched", {4'h0, ref_div_o}, 18'h0);
  endtask

  task automatic t_ref_load();
    send_frame(18'h3D2A5, 1'b1);
    le_high(); le_low();
    check("R3 ref low bits", {4'h0, ref_div_o}, 18'h12A5);
    check("R4 main untouched", {6'h0, main_div_o}, 18'hAD7);
    check("R4 swallow untouched", {12'h0, swallow_o}, 18'h07);
    send_frame(18'h012A5, 1'b1);
    le_high(); le_low();
    check("R3 upper bits ignored", {4'h0, ref_div_o}, 18'h12A5);
  endtask

  task automatic t_no_le();
    send_frame(18'h15555, 1'b0);
    send_frame(18'h0AAAA, 1'b1);
    check_all("R5 no strobe");
  endtask

  task automatic t_transparent();
    send_frame(18'h00F0F, 1'b1);
    le_high();
    check_all("R6 initial");
    shift_bit(1'b1);
    check_all("R6 follow ref");
    shift_bit(1'b0);
    check_all("R6 flag switch to main");
    shift_bit(1'b0);
    check_all("R6 follow main");
    le_low();
    check_all("R6 after strobe");
  endtask

  task automatic t_hold();
    logic [13:0] r = m_ref;
    logic [5:0]  s = m_sw;
    logic [11:0] n = m_mn;
    send_frame(18'h3FFFF, 1'b1);
    shift_bit(1'b0);
    check("R7 ref held", {4'h0, ref_div_o}, {4'h0, r});
    check("R7 swallow held", {12'h0, swallow_o}, {12'h0, s});
    check("R7 main held", {6'h0, main_div_o}, {6'h0, n});
  endtask

  task automatic t_data_no_clk();
    for (int i = 0; i < 18; i++) begin
      shift_bit(i[0]);
      @(negedge clk_i);
      ser_data_i = ~ser_data_i;
      wait_n(5);
      ser_data_i = ~ser_data_i;
      wait_n(5);
    end
    shift_bit(1'b0);
    le_high(); le_low();
    check("R8 swallow", {12'h0, swallow_o}, 18'h2A);
    check("R8 main", {6'h0, main_div_o}, 18'hAAA);
  endtask

  task automatic t_bounds();
    send_frame(18'h3FFFF, 1'b0);
    le_high(); le_low();
    check("R9 swallow max", {12'h0, swallow_o}, 18'd63);
    check("R9 main max", {6'h0, main_div_o}, 18'd4095);
    send_frame(18'h3FFFF, 1'b1);
    le_high(); le_low();
    check("R9 ref max", {4'h0, ref_div_o}, 18'd16383);
  endtask

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(3);
    t_reset();
    t_main_load();
    t_ref_load();
    t_no_le();
    t_transparent();
    t_hold();
    t_data_no_clk();
    t_bounds();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule